// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a byte-wide flash device. It waits for an embedded program or erase operation to finish. After the host has issued the command sequence, it pulses `start_i`. With the pulse it gives the operation kind, a poll address inside the sector being worked on, and, for a program, the byte that was written. The poller then issues status reads through a simple strobe-and-return read port. It interprets the status bits of each byte and reports a single done pulse with a pass, fail or timeout result.

Two completion methods are selectable per run:
- **Bit-7 data polling.** Bit 7 of the status byte is compared with its expected final value.
- **Toggle detection.** Bit 6 is compared between two consecutive reads.

Status and array data can settle at different moments. For that reason the block never trusts the byte that first shows completion. It always takes the result byte from one extra read.

A raised bit 5 (exceeded limit) is treated only as a hint. The block keeps polling and declares failure only when the operation still looks active afterwards. The poll address must lie in an unprotected sector that is the target of the operation; the block does not check this.

Top module: `flash_done_poller`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_en_o`, `pass_o` and `timeout_o` are all 0.
- R2: Every read strobe `rd_en_o` lasts exactly one cycle and is followed by at least one cycle with the strobe low. `rd_addr_o` always equals the address latched at start. Read data is taken in the cycle after the strobe.
- R3: In bit-7 mode (`method_toggle_i`=0), an erase (`op_erase_i`=1) is complete when bit 7 of a status byte is 1. A program (`op_erase_i`=0) is complete when bit 7 equals bit 7 of `exp_data_i`.
- R4: In toggle mode (`method_toggle_i`=1), the first status read only records bit 6. Each later read is complete when its bit 6 equals bit 6 of the previous read, and still running when the two differ.
- R5: Once a status read shows completion, exactly one further read is made and `data_o` takes that byte. A program passes only if the byte equals `exp_data_i`. An erase passes whatever the byte holds.
- R6: A status read that shows the operation running with bit 5 = 1 arms a re-check. If the next two status reads both still show it running, the run ends with `pass_o`=0 and `timeout_o`=0, no extra read is made, and `data_o` holds the last status byte. If completion is seen first, R5 applies.
- R7: When `MAX_POLLS` status reads have been made without completion or failure, the run ends with `timeout_o`=1 and `pass_o`=0, with no extra read.
- R8: `done_o` is a one-cycle pulse that occurs with `busy_o` low. `pass_o`, `timeout_o` and `data_o` then hold until the next accepted start.
- R9: A `start_i` pulse while `busy_o` is high is ignored. Address, operation and expected data of the running poll are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a poll run (accepted when idle) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| method_toggle_i | input | 1 | 1 = bit-6 toggle method, 0 = bit-7 method |
| addr_i | input | AW | Poll address inside the target sector |
| exp_data_i | input | 8 | Byte written by the program operation |
| rd_en_o | output | 1 | Read strobe, one cycle |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | 8 | Read data, valid the cycle after the strobe |
| busy_o | output | 1 | Poll run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run ended successfully |
| timeout_o | output | 1 | Run ended on the poll limit |
| data_o | output | 8 | Result byte |

## Verification
The wrong internal states that matter show up at the ports within one or two poll periods, so the bench can see them.
- A mis-decoded status bit shows as a wrong read count: the final confirming read comes early or late, and the bench counts every strobe.
- A lost toggle history or a stale re-check counter shifts the fail decision by one status read.
- A missing final read leaves `data_o` holding a status byte instead of the array byte.
- A back-to-back strobe is caught on the very next cycle.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_EV,
    S_FRD,
    S_FEV
  } fpoll_state_t;

  // Bit-7 method: still running while bit 7 differs from its final value.
  function automatic logic bit7_running(input logic erase, input logic exp7,
                                        input logic [7:0] d);
    return erase ? ~d[7] : (d[7] != exp7);
  endfunction

  // Toggle method: still running while bit 6 changed since the last read.
  function automatic logic bit6_running(input logic prev6, input logic [7:0] d);
    return prev6 != d[6];
  endfunction

endpackage

// File: rtl/fpoll_status.sv
module fpoll_status
  import fpoll_pkg::*;
(
  input  logic       toggle_mode,
  input  logic       erase,
  input  logic       exp7,
  input  logic       have_prev,
  input  logic       prev6,
  input  logic [7:0] rd_byte,
  output logic       decided,
  output logic       running,
  output logic       limit_flag
);
  always_comb begin
    decided    = !toggle_mode || have_prev;
    running    = toggle_mode ? bit6_running(prev6, rd_byte)
                             : bit7_running(erase, exp7, rd_byte);
    limit_flag = rd_byte[5];
  end
endmodule

// File: rtl/fpoll_ctr.sv
module fpoll_ctr #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int AW        = 19,
  parameter int MAX_POLLS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          method_toggle_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    exp_data_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          timeout_o,
  output logic [7:0]    data_o
);
  fpoll_state_t st_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    exp_q, data_q;
  logic          erase_q, toggle_q, have_prev_q, prev6_q, armed_q;
  logic          rc_q, done_q, pass_q, tmo_q;

  // Named internal events, also used by the bound checker.
  logic eval_w, decided_w, running_w, dq5_w, last_w;
  logic complete_w, busy_read_w, arm_w, recheck_w, fail_w, limit_w, accept_w;

  fpoll_status u_status (
    .toggle_mode (toggle_q),
    .erase       (erase_q),
    .exp7        (exp_q[7]),
    .have_prev   (have_prev_q),
    .prev6       (prev6_q),
    .rd_byte     (rd_data_i),
    .decided     (decided_w),
    .running     (running_w),
    .limit_flag  (dq5_w)
  );

  fpoll_ctr #(.MAX_POLLS(MAX_POLLS)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_w),
    .inc   (eval_w),
    .last  (last_w)
  );

  assign accept_w    = (st_q == S_IDLE) && start_i;
  assign eval_w      = (st_q == S_EV);
  assign complete_w  = eval_w && decided_w && !running_w;
  assign busy_read_w = eval_w && decided_w && running_w;
  assign arm_w       = busy_read_w && !armed_q && dq5_w;
  assign recheck_w   = busy_read_w && armed_q;
  assign fail_w      = recheck_w && rc_q;
  assign limit_w     = eval_w && last_w && !complete_w && !fail_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      addr_q      <= '0;
      exp_q       <= '0;
      data_q      <= '0;
      erase_q     <= 1'b0;
      toggle_q    <= 1'b0;
      have_prev_q <= 1'b0;
      prev6_q     <= 1'b0;
      armed_q     <= 1'b0;
      rc_q        <= 1'b0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      tmo_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          addr_q      <= addr_i;
          exp_q       <= exp_data_i;
          erase_q     <= op_erase_i;
          toggle_q    <= method_toggle_i;
          have_prev_q <= 1'b0;
          armed_q     <= 1'b0;
          rc_q        <= 1'b0;
          pass_q      <= 1'b0;
          tmo_q       <= 1'b0;
          st_q        <= S_RD;
        end
        S_RD: st_q <= S_EV;
        S_EV: begin
          data_q      <= rd_data_i;
          prev6_q     <= rd_data_i[6];
          have_prev_q <= 1'b1;
          if (complete_w) begin
            st_q <= S_FRD;
          end else if (fail_w) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (limit_w) begin
            tmo_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            if (arm_w)     armed_q <= 1'b1;
            if (recheck_w) rc_q    <= 1'b1;
            st_q <= S_RD;
          end
        end
        S_FRD: st_q <= S_FEV;
        S_FEV: begin
          data_q <= rd_data_i;
          pass_q <= erase_q || (rd_data_i == exp_q);
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_en_o   = (st_q == S_RD) || (st_q == S_FRD);
  assign rd_addr_o = addr_q;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign timeout_o = tmo_q;
  assign data_o    = data_q;
endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          timeout,
  input logic          complete_evt,
  input logic          fail_evt
);
  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr));

  a_r5_final_read: assert property (@(posedge clk) disable iff (!rst_n)
    complete_evt |=> rd_en);

  a_r6_fail_result: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (done && !pass && !timeout && !rd_en));

  a_r7_timeout_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !pass);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind flash_done_poller fpoll_checker #(.AW(AW)) u_fpoll_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en_o),
  .rd_addr      (rd_addr_o),
  .busy         (busy_o),
  .done         (done_o),
  .pass         (pass_o),
  .timeout      (timeout_o),
  .complete_evt (complete_w),
  .fail_evt     (fail_w)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
  localparam int AW = 19;
  localparam int MP = 6;

  typedef struct packed {
    logic            erase;
    logic            toggle;
    logic [7:0]      exp;
    logic [0:7][7:0] resp;
    logic            pass;
    logic            tmo;
    logic [7:0]      data;
    logic [3:0]      reads;
  } vec_t;

  // Columns: erase, toggle, expected byte, read responses, pass, timeout, data, reads
  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 8'hA5, '{8'h25, 8'h25, 8'hA5, 8'hA5, 8'h0, 8'h0, 8'h0, 8'h0}, 1'b1, 1'b0, 8'hA5, 4'd4}, // R3 program
    '{1'b1, 1'b0, 8'h00, '{8'h00, 8'h40, 8'h80, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0}, 1'b1, 1'b0, 8'hFF, 4'd4}, // R3 erase
    '{1'b0, 1'b1, 8'h3C, '{8'h40, 8'h00, 8'h40, 8'h40, 8'h3C, 8'h0, 8'h0, 8'h0}, 1'b1, 1'b0, 8'h3C, 4'd5}, // R4 toggle
    '{1'b0, 1'b0, 8'h81, '{8'h81, 8'h80, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, 1'b0, 1'b0, 8'h80, 4'd2},    // R5 mismatch
    '{1'b1, 1'b0, 8'h00, '{8'h20, 8'h20, 8'h80, 8'h12, 8'h0, 8'h0, 8'h0, 8'h0}, 1'b1, 1'b0, 8'h12, 4'd4}, // R6 recovers
    '{1'b1, 1'b0, 8'h00, '{8'h20, 8'h20, 8'h20, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0}, 1'b0, 1'b0, 8'h20, 4'd3}, // R6 fail
    '{1'b0, 1'b1, 8'h55, '{8'h60, 8'h20, 8'h60, 8'h20, 8'h60, 8'h0, 8'h0, 8'h0}, 1'b0, 1'b0, 8'h20, 4'd4}, // R6 toggle fail
    '{1'b0, 1'b0, 8'h80, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 1'b0, 1'b1, 8'h00, 4'd6}, // R7 timeout
    '{1'b0, 1'b1, 8'h11, '{8'h60, 8'h20, 8'h20, 8'h11, 8'h0, 8'h0, 8'h0, 8'h0}, 1'b1, 1'b0, 8'h11, 4'd4}  // R6 toggle stops
  };

  logic clk = 0, rst_n = 0, start_i = 0, op_erase_i = 0, method_toggle_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] exp_data_i = '0, rd_data_i = '0;
  logic rd_en_o, busy_o, done_o, pass_o, timeout_o;
  logic [AW-1:0] rd_addr_o;
  logic [7:0] data_o;

  int checks = 0, errors = 0;
  int nreads = 0, ridx = 0, addr_bad = 0;
  logic [0:7][7:0] resp = '0;
  logic [AW-1:0] cur_addr = '0;

  always #10 clk = ~clk;

  flash_done_poller #(.AW(AW), .MAX_POLLS(MP)) u_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .method_toggle_i(method_toggle_i), .addr_i(addr_i), .exp_data_i(exp_data_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .timeout_o(timeout_o),
    .data_o(data_o)
  );

  // Read responder: data appears before the edge after the strobe.
  always @(negedge clk) begin
    if (rd_en_o) begin
      rd_data_i = resp[ridx];
      if (ridx < 7) ridx++;
      nreads++;
      if (rd_addr_o !== cur_addr) addr_bad++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(input vec_t v, input logic [AW-1:0] a);
    @(negedge clk);
    resp = v.resp; ridx = 0; nreads = 0; addr_bad = 0; cur_addr = a;
    op_erase_i = v.erase; method_toggle_i = v.toggle; exp_data_i = v.exp;
    addr_i = a; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done;
    for (int k = 0; k < 100 && !done_o; k++) @(negedge clk);
  endtask

  task automatic judge(input vec_t v, input string tag);
    check({tag, " done pulse"}, done_o, 1);
    check({tag, " R8 busy low at done"}, busy_o, 0);
    check({tag, " pass"}, pass_o, v.pass);
    check({tag, " R7 timeout"}, timeout_o, v.tmo);
    check({tag, " R5 data"}, data_o, v.data);
    check({tag, " read count"}, nreads, v.reads);
    check({tag, " R2 address"}, addr_bad, 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 rd_en", rd_en_o, 0);
    check("R1 pass", pass_o, 0);
    check("R1 timeout", timeout_o, 0);
    rst_n = 1;

    for (int i = 0; i < 9; i++) begin
      launch(VEC[i], AW'(19'h1000 + i * 19'h111));
      wait_done();
      judge(VEC[i], $sformatf("vec%0d", i));
    end

    // R8 results hold after the pulse
    repeat (3) @(negedge clk);
    check("R8 done dropped", done_o, 0);
    check("R8 pass held", pass_o, VEC[8].pass);
    check("R8 data held", data_o, VEC[8].data);

    // R9 start while busy is ignored
    launch(VEC[0], 19'h2AAAA);
    @(negedge clk);
    op_erase_i = 1; method_toggle_i = 1; exp_data_i = 8'h00; addr_i = 19'h05555; start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_done();
    judge(VEC[0], "R9 ignored start");

    // R7 timeout in toggle mode with constant toggling
    begin
      vec_t t;
      t = '{1'b1, 1'b1, 8'h00, '{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00},
            1'b0, 1'b1, 8'h00, 4'd6};
      launch(t, 19'h7FFFF);
      wait_done();
      judge(t, "R7 toggle timeout");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule